// File: doc/BRIEF.md
# Pending-to-Posted Interrupt Controller

This block collects interrupt events from a fixed set of sources and hands them to a host one at a time. Each source has three bits. An enable bit is written by the host. A pending bit is set by the source whenever it has something to report. A posted bit tells the host which source is currently interrupting it. Sources may raise pending at any time during a service pass. The decision to post is taken only when the pass-end strobe arrives.

On that strobe, the controller posts a source only when no source is posted already. It takes the lowest-numbered source that is both pending and enabled. The chosen bit moves from pending to posted, and the host request line rises. The host reads the posted vector to learn the source, then clears the posted bit with a write-one-to-clear mask. The next pass end can then post the next candidate. Bus decoding and the vector cycle are handled elsewhere.

Top module: `irq_post_ctrl`

## Requirements
- R1: After reset, the enable, pending and posted vectors are all zero and the host request is low.
- R2: A one on bit i of `set_i` makes pending bit i one on the following cycle. That bit stays one, whatever its enable, until the source is posted.
- R3: No posted bit becomes one in a cycle that follows a cycle without `pass_end_i`.
- R4: A source whose enable bit is zero is never posted, even while pending.
- R5: While any posted bit is one, a pass end posts nothing and leaves all pending bits in place.
- R6: At a pass end with nothing posted, the pending-and-enabled source with the lowest index (bit 0 is highest priority) is posted. Its pending bit clears and exactly one posted bit becomes one, on the next cycle.
- R7: `irq_o` is high exactly when at least one posted bit is one.
- R8: A write with `clr_wr_i` clears each posted bit whose mask bit is one. Mask bits that are zero leave posted bits unchanged.
- R9: A pending set that arrives in the same cycle as a pass end is not considered in that pass. It stays pending for a later pass.
- R10: A write with `en_wr_i` replaces the whole enable vector with `en_wdata_i`, and the result is visible on `enable_o` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_i | input | NSRC | Per-source pending set strobes |
| pass_end_i | input | 1 | End-of-service-pass strobe that triggers the posting decision |
| en_wr_i | input | 1 | Enable vector write strobe |
| en_wdata_i | input | NSRC | New enable vector |
| clr_wr_i | input | 1 | Posted vector clear strobe |
| clr_mask_i | input | NSRC | Write-one-to-clear mask for posted bits |
| enable_o | output | NSRC | Current enable vector |
| pending_o | output | NSRC | Current pending vector |
| posted_o | output | NSRC | Current posted vector |
| irq_o | output | 1 | Host interrupt request |

## Verification
The assertions assume that every input is a clean synchronous level, sampled at the rising edge. They also assume that a clear only has meaning for bits already posted, so a mask with extra ones does no harm. The bench changes inputs only on the falling edge and holds each strobe for exactly one cycle. It tracks the expected vectors by hand from the requirements. This includes passes that run with a source already posted, and passes that meet a fresh pending set in the same cycle.

// File: rtl/irq_post_pkg.sv
package irq_post_pkg;
  localparam int unsigned IRQ_NSRC_DEF = 16;

  // Post decision for one pass
  typedef enum logic [1:0] {
    POST_IDLE  = 2'd0,
    POST_BUSY  = 2'd1,
    POST_EMPTY = 2'd2,
    POST_TAKE  = 2'd3
  } post_dec_e;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  logic [N-1:0] blocked;

  assign blocked[0] = 1'b0;
  genvar gi;
  generate
    for (gi = 1; gi < N; gi++) begin : g_chain
      assign blocked[gi] = blocked[gi-1] | req_i[gi-1];
    end
    for (gi = 0; gi < N; gi++) begin : g_grant
      assign grant_o[gi] = req_i[gi] & ~blocked[gi];
    end
  endgenerate

  assign any_o = |req_i;
endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_wr_i,
  input  logic [N-1:0] en_wdata_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] take_i,
  input  logic         clr_wr_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] enable_q,
  output logic [N-1:0] pending_q,
  output logic [N-1:0] posted_q
);
  logic [N-1:0] enable_d, pending_d, posted_d;
  logic [N-1:0] clr_eff;

  always_comb begin
    clr_eff   = clr_wr_i ? clr_mask_i : '0;
    enable_d  = en_wr_i ? en_wdata_i : enable_q;
    // a fresh set wins over the take of the same cycle
    pending_d = (pending_q & ~take_i) | set_i;
    posted_d  = (posted_q & ~clr_eff) | take_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q  <= '0;
      pending_q <= '0;
      posted_q  <= '0;
    end else begin
      enable_q  <= enable_d;
      pending_q <= pending_d;
      posted_q  <= posted_d;
    end
  end
endmodule

// File: rtl/irq_post_ctrl.sv
module irq_post_ctrl
  import irq_post_pkg::*;
#(
  parameter int unsigned NSRC = IRQ_NSRC_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic            pass_end_i,
  input  logic            en_wr_i,
  input  logic [NSRC-1:0] en_wdata_i,
  input  logic            clr_wr_i,
  input  logic [NSRC-1:0] clr_mask_i,
  output logic [NSRC-1:0] enable_o,
  output logic [NSRC-1:0] pending_o,
  output logic [NSRC-1:0] posted_o,
  output logic            irq_o
);
  logic [NSRC-1:0] enable_q, pending_q, posted_q;
  logic [NSRC-1:0] cand, grant, take;
  logic            cand_any;
  post_dec_e       dec;

  assign cand = pending_q & enable_q;

  irq_prio_pick #(.N(NSRC)) u_pick (
    .req_i   (cand),
    .grant_o (grant),
    .any_o   (cand_any)
  );

  always_comb begin
    if (!pass_end_i)      dec = POST_IDLE;
    else if (|posted_q)   dec = POST_BUSY;
    else if (!cand_any)   dec = POST_EMPTY;
    else                  dec = POST_TAKE;
    take = (dec == POST_TAKE) ? grant : '0;
  end

  irq_state_regs #(.N(NSRC)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_wr_i    (en_wr_i),
    .en_wdata_i (en_wdata_i),
    .set_i      (set_i),
    .take_i     (take),
    .clr_wr_i   (clr_wr_i),
    .clr_mask_i (clr_mask_i),
    .enable_q   (enable_q),
    .pending_q  (pending_q),
    .posted_q   (posted_q)
  );

  assign enable_o  = enable_q;
  assign pending_o = pending_q;
  assign posted_o  = posted_q;
  assign irq_o     = |posted_q;
endmodule

// File: rtl/irq_post_ctrl_chk.sv
module irq_post_ctrl_chk #(
  parameter int unsigned NSRC = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pass_end_i,
  input logic            clr_wr_i,
  input logic [NSRC-1:0] clr_mask_i,
  input logic [NSRC-1:0] enable_o,
  input logic [NSRC-1:0] pending_o,
  input logic [NSRC-1:0] posted_o,
  input logic            irq_o
);
  a_r3_post_only_after_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !pass_end_i |=> ((posted_o & ~$past(posted_o)) == '0));

  a_r3_irq_rise_after_pass: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(pass_end_i));

  a_r4_only_enabled_posted: assert property (@(posedge clk) disable iff (!rst_n)
    pass_end_i |=> ((posted_o & ~$past(posted_o) & ~$past(enable_o)) == '0));

  a_r5_single_posted: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(posted_o));

  a_r5_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_end_i && (posted_o != '0)) |=> ((posted_o & ~$past(posted_o)) == '0));

  a_r2_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pending_o) & ~pending_o & ~(posted_o & ~$past(posted_o))) == '0));

  a_r8_clear_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr_i |=> ((posted_o & $past(clr_mask_i & posted_o)) == '0));
endmodule

bind irq_post_ctrl irq_post_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pass_end_i (pass_end_i),
  .clr_wr_i   (clr_wr_i),
  .clr_mask_i (clr_mask_i),
  .enable_o   (enable_o),
  .pending_o  (pending_o),
  .posted_o   (posted_o),
  .irq_o      (irq_o)
);

// File: tb/tb_irq_post_ctrl.sv
module tb_irq_post_ctrl;
  localparam int N = 16;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] set_i;
  logic         pass_end_i;
  logic         en_wr_i;
  logic [N-1:0] en_wdata_i;
  logic         clr_wr_i;
  logic [N-1:0] clr_mask_i;
  logic [N-1:0] enable_o, pending_o, posted_o;
  logic         irq_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  irq_post_ctrl #(.NSRC(N)) dut (
    .clk(clk), .rst_n(rst_n), .set_i(set_i), .pass_end_i(pass_end_i),
    .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i), .clr_wr_i(clr_wr_i),
    .clr_mask_i(clr_mask_i), .enable_o(enable_o), .pending_o(pending_o),
    .posted_o(posted_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [N-1:0] en,
                         input logic [N-1:0] pe, input logic [N-1:0] po);
    chk(req, "enable", enable_o, en);
    chk(req, "pending", pending_o, pe);
    chk(req, "posted", posted_o, po);
    chk(req, "irq", {{(N-1){1'b0}}, irq_o}, {{(N-1){1'b0}}, (po != '0)});
  endtask

  // one cycle: inputs applied at a falling edge, removed at the next
  task automatic step(input logic [N-1:0] s, input logic pe,
                      input logic ew, input logic [N-1:0] ed,
                      input logic cw, input logic [N-1:0] cm);
    set_i = s; pass_end_i = pe; en_wr_i = ew; en_wdata_i = ed;
    clr_wr_i = cw; clr_mask_i = cm;
    @(negedge clk);
    set_i = '0; pass_end_i = 1'b0; en_wr_i = 1'b0; clr_wr_i = 1'b0;
  endtask

  task automatic t_reset;
    chk_all("R1", '0, '0, '0);
  endtask

  task automatic t_set_disabled;
    step(16'h0028, 1'b0, 1'b0, '0, 1'b0, '0);
    chk_all("R2", '0, 16'h0028, '0);
    step('0, 1'b1, 1'b0, '0, 1'b0, '0);
    chk_all("R4", '0, 16'h0028, '0);
  endtask

  task automatic t_enable_no_pass;
    step('0, 1'b0, 1'b1, 16'hFFFF, 1'b0, '0);
    chk("R10", "enable", enable_o, 16'hFFFF);
    for (int i = 0; i < 3; i++) step('0, 1'b0, 1'b0, '0, 1'b0, '0);
    chk_all("R3", 16'hFFFF, 16'h0028, '0);
  endtask

  task automatic t_pick;
    step('0, 1'b1, 1'b0, '0, 1'b0, '0);
    chk_all("R6", 16'hFFFF, 16'h0020, 16'h0008);
    chk("R7", "irq high", {15'b0, irq_o}, 16'h0001);
  endtask

  task automatic t_blocked;
    step('0, 1'b1, 1'b0, '0, 1'b0, '0);
    chk_all("R5", 16'hFFFF, 16'h0020, 16'h0008);
  endtask

  task automatic t_clear;
    step('0, 1'b0, 1'b0, '0, 1'b1, 16'hFFF7);
    chk_all("R8", 16'hFFFF, 16'h0020, 16'h0008);
    step('0, 1'b0, 1'b0, '0, 1'b1, 16'h0008);
    chk_all("R8", 16'hFFFF, 16'h0020, '0);
    chk("R7", "irq low", {15'b0, irq_o}, 16'h0000);
  endtask

  task automatic t_same_cycle;
    step(16'h0002, 1'b1, 1'b0, '0, 1'b0, '0);
    chk_all("R9", 16'hFFFF, 16'h0002, 16'h0020);
    step('0, 1'b0, 1'b0, '0, 1'b1, 16'h0020);
    step('0, 1'b1, 1'b0, '0, 1'b0, '0);
    chk_all("R9", 16'hFFFF, 16'h0000, 16'h0002);
    step('0, 1'b0, 1'b0, '0, 1'b1, 16'h0002);
  endtask

  task automatic t_enable_mask;
    step('0, 1'b0, 1'b1, 16'h00F0, 1'b0, '0);
    chk("R10", "enable replace", enable_o, 16'h00F0);
    step(16'h0081, 1'b0, 1'b0, '0, 1'b0, '0);
    step('0, 1'b1, 1'b0, '0, 1'b0, '0);
    chk_all("R4", 16'h00F0, 16'h0001, 16'h0080);
    step('0, 1'b0, 1'b0, '0, 1'b1, 16'h0080);
  endtask

  task automatic t_top_bits;
    step('0, 1'b0, 1'b1, 16'hC000, 1'b0, '0);
    step(16'hC000, 1'b0, 1'b0, '0, 1'b0, '0);
    step('0, 1'b1, 1'b0, '0, 1'b0, '0);
    chk_all("R6", 16'hC000, 16'h8001, 16'h4000);
    step('0, 1'b0, 1'b0, '0, 1'b1, 16'h4000);
    step('0, 1'b1, 1'b0, '0, 1'b0, '0);
    chk_all("R6", 16'hC000, 16'h0001, 16'h8000);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    set_i = '0; pass_end_i = 1'b0; en_wr_i = 1'b0; en_wdata_i = '0;
    clr_wr_i = 1'b0; clr_mask_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_disabled();
    t_enable_no_pass();
    t_pick();
    t_blocked();
    t_clear();
    t_same_cycle();
    t_enable_mask();
    t_top_bits();
    finish_run();
  end
endmodule